// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Register Slave

This block is a synchronous slave for a two-wire SMBus/I2C-style bus. It runs entirely on the system clock. It samples the bus clock and data lines through a short synchronizer and finds the bus events by watching for edges. The bus data line is open-drain, so the block never drives a high level. It only asserts an enable that pulls the line low. A pad cell or the bench turns that enable into the wired-AND line.

The 7-bit slave address is built from a parameter base in the upper five bits and two strap inputs in the lower two bits. The strap inputs are captured while reset is held and are then frozen, so one part number can sit at any of four addresses on a shared bus. Pads are expected to pull an unconnected strap low, so an open strap reads as 0.

A write transfer carries a register index byte and then data bytes. Each data byte produces one write strobe toward a simple register file. After each data byte the internal register pointer moves on by one. A read transfer is usually placed after a repeated START that follows a write of the index byte. It returns the byte at the pointer, and the pointer moves on each time the master acknowledges a byte.

Top module: `smb_regport`

## Requirements
- R1: The 7-bit slave address is {BASE_ADDR[6:2], strap_i}, captured while rst_n is low. Changes on strap_i after reset do not change which address the slave answers.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A STOP at any point returns the slave to idle with SDA released.
- R3: Bytes travel most significant bit first. In the address byte, bits 7:1 are the slave address and bit 0 is the direction, with 0 meaning write and 1 meaning read. A matching address byte is acknowledged by pulling SDA low for the ninth clock.
- R4: An address byte that does not match is not acknowledged. The slave then ignores all bytes until the next START, and it issues no strobe.
- R5: In a write, the first byte after the address loads the register pointer and is acknowledged. Each following byte is acknowledged and produces one reg_wr_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte. The pointer then advances by one.
- R6: A STOP that arrives before the eighth bit of a data byte produces no write strobe.
- R7: A read addressed to the slave returns the byte at the register pointer. reg_rd_o pulses with reg_addr_o equal to the pointer, and reg_rdata_i is taken in that same cycle.
- R8: In a read, a master ACK (SDA low on the ninth clock) advances the pointer and starts the next byte. A master NACK ends the read: SDA stays released and no further read strobe is issued.
- R9: sda_drive_o only becomes asserted while the synchronized SCL is low.
- R10: reg_wr_o and reg_rd_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; straps are captured while it is low |
| strap_i | input | 2 | Address strap pins, the low two bits of the slave address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_o | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | 8 | Register index for either strobe |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rdata_i | input | 8 | Read data; must be valid in the cycle reg_rd_o is high |

## Verification
The bench builds the block with the default base address 7'h58 and holds the straps at 2'b01 through reset. After reset it moves the straps to 2'b10, so two addresses that differ only in their strap bits are both on hand. One must be acknowledged and the other must be ignored. A bus clock half period of twenty system clocks leaves room for the synchronizer delay. Write, read-with-advance, NACK termination and a STOP in the middle of a byte are then all driven as ordinary bus traffic. The outcome of each is read back through later bus reads.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int DEV_W       = 7;
    localparam int STRAP_W     = 2;
    localparam int BYTE_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int CNT_W       = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKW,
        ST_ACK,
        ST_LOAD,
        ST_TX,
        ST_MACK,
        ST_NEXT,
        ST_SKIP
    } st_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_REG,
        RX_DATA
    } rx_e;

    typedef struct packed {
        logic [SYNC_STAGES:0] scl;
        logic [SYNC_STAGES:0] sda;
    } sense_t;

    typedef struct packed {
        st_e               st;
        rx_e               kind;
        logic              rw;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] ptr;
        logic              drive;
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic [DEV_W-1:0]  dev;
    } core_t;

endpackage

// File: rtl/smb_line_sense.sv
module smb_line_sense
    import smb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    sense_t q, d;

    always_comb begin
        d     = q;
        d.scl = {q.scl[SYNC_STAGES-1:0], scl_i};
        d.sda = {q.sda[SYNC_STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = q.scl[SYNC_STAGES-1];
    assign scl_old = q.scl[SYNC_STAGES];
    assign sda_now = q.sda[SYNC_STAGES-1];
    assign sda_old = q.sda[SYNC_STAGES];

    assign scl_s_o    = scl_now;
    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
    import smb_pkg::*;
#(
    parameter logic [DEV_W-1:0] BASE_ADDR = 7'h58
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_s,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [BYTE_W-1:0]  reg_rdata_i,
    output logic               sda_drive_o,
    output logic               reg_wr_o,
    output logic               reg_rd_o,
    output logic [BYTE_W-1:0]  reg_addr_o,
    output logic [BYTE_W-1:0]  reg_wdata_o,
    output logic [DEV_W-1:0]   dev_addr_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    core_t q, d, rst_val;
    logic [BYTE_W-1:0] byte_in;

    assign byte_in = {q.sh[BYTE_W-2:0], sda_s};

    always_comb begin
        rst_val     = '0;
        rst_val.dev = {BASE_ADDR[DEV_W-1:STRAP_W], strap_i};
    end

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        d.rd = 1'b0;
        if (stop_det) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
        end else if (start_det) begin
            d.st    = ST_RX;
            d.kind  = RX_ADDR;
            d.cnt   = '0;
            d.drive = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT) begin
                            d.cnt = '0;
                            d.st  = ST_ACKW;
                            unique case (q.kind)
                                RX_ADDR: begin
                                    if (byte_in[BYTE_W-1:1] == q.dev) begin
                                        d.rw = byte_in[0];
                                    end else begin
                                        d.st = ST_SKIP;
                                    end
                                end
                                RX_REG: d.ptr = byte_in;
                                default: begin
                                    d.wr    = 1'b1;
                                    d.addr  = q.ptr;
                                    d.wdata = byte_in;
                                    d.ptr   = q.ptr + 1'b1;
                                end
                            endcase
                        end
                    end
                end
                ST_ACKW: begin
                    if (scl_fall) begin
                        d.drive = 1'b1;
                        d.st    = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.drive = 1'b0;
                        if (q.kind == RX_ADDR && q.rw) begin
                            d.st   = ST_LOAD;
                            d.rd   = 1'b1;
                            d.addr = q.ptr;
                        end else begin
                            d.st   = ST_RX;
                            d.cnt  = '0;
                            d.kind = (q.kind == RX_ADDR) ? RX_REG : RX_DATA;
                        end
                    end
                end
                ST_LOAD: begin
                    d.sh    = reg_rdata_i;
                    d.drive = ~reg_rdata_i[BYTE_W-1];
                    d.cnt   = '0;
                    d.st    = ST_TX;
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.drive = 1'b0;
                            d.st    = ST_MACK;
                        end else begin
                            d.sh    = {q.sh[BYTE_W-2:0], 1'b0};
                            d.drive = ~q.sh[BYTE_W-2];
                            d.cnt   = q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_NEXT;
                        end else begin
                            d.st  = ST_SKIP;
                        end
                    end
                end
                ST_NEXT: begin
                    if (scl_fall) begin
                        d.rd   = 1'b1;
                        d.addr = q.ptr;
                        d.st   = ST_LOAD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= rst_val;
        end else begin
            q <= d;
        end
    end

    assign sda_drive_o = q.drive;
    assign reg_wr_o    = q.wr;
    assign reg_rd_o    = q.rd;
    assign reg_addr_o  = q.addr;
    assign reg_wdata_o = q.wdata;
    assign dev_addr_o  = q.dev;

endmodule

// File: rtl/smb_regport.sv
module smb_regport
    import smb_pkg::*;
#(
    parameter logic [DEV_W-1:0] BASE_ADDR = 7'h58
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  strap_i,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_drive_o,
    output logic        reg_wr_o,
    output logic        reg_rd_o,
    output logic [7:0]  reg_addr_o,
    output logic [7:0]  reg_wdata_o,
    input  logic [7:0]  reg_rdata_i
);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DEV_W-1:0] dev_addr;

    smb_line_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    smb_slave_fsm #(
        .BASE_ADDR (BASE_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_i),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .sda_s       (sda_s),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .reg_rdata_i (reg_rdata_i),
        .sda_drive_o (sda_drive_o),
        .reg_wr_o    (reg_wr_o),
        .reg_rd_o    (reg_rd_o),
        .reg_addr_o  (reg_addr_o),
        .reg_wdata_o (reg_wdata_o),
        .dev_addr_o  (dev_addr)
    );

endmodule

// File: rtl/smb_regport_chk.sv
module smb_regport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic [6:0] dev_addr,
    input logic       sda_drive_o,
    input logic       reg_wr_o,
    input logic       reg_rd_o
);

    // R1: the captured address never moves once out of reset
    a_r1_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(dev_addr));

    // R2: a STOP leaves the data line released
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_o);

    // R9: the pull-down only starts while the clock is low
    a_r9_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_o) |-> !$past(scl_s));

    // R10: strobes last one cycle and never overlap
    a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));

endmodule

bind smb_regport smb_regport_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .stop_det    (stop_det),
    .dev_addr    (dev_addr),
    .sda_drive_o (sda_drive_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o)
);

// File: tb/tb_smb_regport.sv
`timescale 1ns/1ps
module tb_smb_regport;

    localparam logic [6:0] BASE  = 7'h58;
    localparam logic [6:0] DEV_A = {BASE[6:2], 2'b01};
    localparam logic [6:0] DEV_B = {BASE[6:2], 2'b10};
    localparam int         H     = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap = 2'b01;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_drive, reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_line;

    logic [7:0]  mem [256];
    logic [15:0] exp_wr [$];
    logic [7:0]  exp_rd [$];
    int          checks = 0;
    int          errors = 0;
    logic        drv_prev = 1'b0;
    logic        done = 1'b0;

    assign sda_line  = sda_m & ~sda_drive;
    assign reg_rdata = mem[reg_addr];

    always #2.5 clk = ~clk;

    smb_regport #(.BASE_ADDR(BASE)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_drive_o (sda_drive),
        .reg_wr_o    (reg_wr),
        .reg_rd_o    (reg_rd),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // reference model: expected strobes from queues, compared each clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (exp_wr.size() == 0) begin
                    check(0, "R5/R6", "unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_wr.pop_front();
                    check({reg_addr, reg_wdata} == e, "R5", "write strobe",
                          {reg_addr, reg_wdata}, e);
                end
                mem[reg_addr] = reg_wdata;
            end
            if (reg_rd) begin
                if (exp_rd.size() == 0) begin
                    check(0, "R8", "unexpected read", reg_addr, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_rd.pop_front();
                    check(reg_addr == e, "R7", "read strobe addr", reg_addr, e);
                end
            end
            if (reg_wr && reg_rd) check(0, "R10", "both strobes", 1, 0);
            if (sda_drive && !drv_prev) check(!scl_m, "R9", "drive rose with SCL high", scl_m, 0);
            drv_prev = sda_drive;
        end
    end

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_h();
        scl_m = 1'b1; wait_h();
        sda_m = 1'b0; wait_h();
        scl_m = 1'b0; wait_h();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_h();
        scl_m = 1'b1; wait_h();
        sda_m = 1'b1; wait_h();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_n);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_h();
            scl_m = 1'b1; wait_h();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_h();
        scl_m = 1'b1;
        repeat (H/2) @(negedge clk);
        ack_n = sda_line;
        repeat (H/2) @(negedge clk);
        scl_m = 1'b0;
        wait_h();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic master_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_h();
            scl_m = 1'b1;
            repeat (H/2) @(negedge clk);
            b[i] = sda_line;
            repeat (H/2) @(negedge clk);
            scl_m = 1'b0;
        end
        sda_m = master_ack ? 1'b0 : 1'b1;
        wait_h();
        scl_m = 1'b1; wait_h();
        scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 7 + 3) & 8'hff);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(0, "WATCHDOG", "run did not finish", 0, 1);
            report();
        end
    end

    initial begin
        logic       ack_n;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strap = 2'b10;   // R1: later strap change must be ignored
        repeat (5) @(negedge clk);

        check(sda_drive == 1'b0, "R9", "reset drive", sda_drive, 0);
        check(reg_wr == 1'b0, "R10", "reset wr", reg_wr, 0);
        check(reg_rd == 1'b0, "R10", "reset rd", reg_rd, 0);

        // R3, R5: single register write at the strap-01 address
        exp_wr.push_back({8'h05, 8'hA7});
        bus_start();
        send_byte({DEV_A, 1'b0}, ack_n); check(ack_n == 0, "R3", "addr ack", ack_n, 0);
        send_byte(8'h05, ack_n);         check(ack_n == 0, "R5", "reg ack", ack_n, 0);
        send_byte(8'hA7, ack_n);         check(ack_n == 0, "R5", "data ack", ack_n, 0);
        bus_stop();
        check(sda_drive == 0, "R2", "released after STOP", sda_drive, 0);
        check(exp_wr.size() == 0, "R5", "write count", exp_wr.size(), 0);

        // R1, R4: address from the new strap value is not ours
        bus_start();
        send_byte({DEV_B, 1'b0}, ack_n); check(ack_n == 1, "R1", "new strap addr nack", ack_n, 1);
        send_byte(8'h05, ack_n);         check(ack_n == 1, "R4", "ignored byte", ack_n, 1);
        send_byte(8'h55, ack_n);         check(ack_n == 1, "R4", "ignored byte", ack_n, 1);
        bus_stop();

        // R7, R8: pointer 0x04, repeated START, read three bytes
        exp_rd.push_back(8'h04); exp_rd.push_back(8'h05); exp_rd.push_back(8'h06);
        bus_start();
        send_byte({DEV_A, 1'b0}, ack_n); check(ack_n == 0, "R3", "addr ack", ack_n, 0);
        send_byte(8'h04, ack_n);         check(ack_n == 0, "R5", "ptr ack", ack_n, 0);
        bus_start();
        send_byte({DEV_A, 1'b1}, ack_n); check(ack_n == 0, "R3", "read addr ack", ack_n, 0);
        recv_byte(b, 1'b1); check(b == init_val(4), "R7", "read byte 0", b, init_val(4));
        recv_byte(b, 1'b1); check(b == 8'hA7, "R4", "ignored write left data", b, 8'hA7);
        recv_byte(b, 1'b0); check(b == init_val(6), "R8", "advanced byte", b, init_val(6));
        wait_h();
        check(sda_drive == 0, "R8", "released after NACK", sda_drive, 0);
        bus_stop();
        check(exp_rd.size() == 0, "R8", "read count", exp_rd.size(), 0);

        // R6: STOP in the middle of a data byte, no write
        bus_start();
        send_byte({DEV_A, 1'b0}, ack_n);
        send_byte(8'h30, ack_n);
        for (int k = 0; k < 4; k++) begin
            sda_m = 1'b1; wait_h();
            scl_m = 1'b1; wait_h();
            scl_m = 1'b0;
        end
        bus_stop();
        check(sda_drive == 0, "R2", "idle after mid-byte STOP", sda_drive, 0);
        exp_rd.push_back(8'h30);
        bus_start();
        send_byte({DEV_A, 1'b0}, ack_n);
        send_byte(8'h30, ack_n);
        bus_start();
        send_byte({DEV_A, 1'b1}, ack_n); check(ack_n == 0, "R2", "accepted after STOP", ack_n, 0);
        recv_byte(b, 1'b0); check(b == init_val(8'h30), "R6", "no partial write", b, init_val(8'h30));
        bus_stop();

        // R5: two data bytes, pointer advances between them
        exp_wr.push_back({8'h20, 8'h11}); exp_wr.push_back({8'h21, 8'h22});
        bus_start();
        send_byte({DEV_A, 1'b0}, ack_n);
        send_byte(8'h20, ack_n);
        send_byte(8'h11, ack_n); check(ack_n == 0, "R5", "burst ack 0", ack_n, 0);
        send_byte(8'h22, ack_n); check(ack_n == 0, "R5", "burst ack 1", ack_n, 0);
        bus_stop();
        exp_rd.push_back(8'h21);
        bus_start();
        send_byte({DEV_A, 1'b0}, ack_n);
        send_byte(8'h21, ack_n);
        bus_start();
        send_byte({DEV_A, 1'b1}, ack_n);
        recv_byte(b, 1'b0); check(b == 8'h22, "R5", "burst second byte", b, 8'h22);
        bus_stop();

        // R1: read direction at the strap-10 address is also ignored
        bus_start();
        send_byte({DEV_B, 1'b1}, ack_n); check(ack_n == 1, "R1", "read at new strap nack", ack_n, 1);
        bus_stop();
        repeat (10) @(negedge clk);
        check(exp_wr.size() == 0 && exp_rd.size() == 0, "R4", "no stray strobes",
              exp_wr.size() + exp_rd.size(), 0);

        done = 1'b1;
        report();
    end

endmodule